// File: doc/BRIEF.md
# GPIO Port with Peripheral Override

A five-pin general-purpose I/O port placed on a small register bus. Software controls each pin through a direction register and an output data latch. It observes the pins through a port register, which returns the pin levels after a two-flop synchronizer. A direction bit of 1 leaves the pin as an input with its driver off. A direction bit of 0 drives the latch bit onto the pin.

Any pin can be claimed by an on-chip peripheral. On those pins a timer capture/compare unit or a serial transmitter/receiver supplies the output data and the output enable through per-pin select, data and enable inputs. The override acts only on the pad-facing outputs. The stored direction register is never modified by it, so software can do read-modify-write on the direction register while peripherals own some of the pins. The synchronized pin levels are also passed back to the peripherals.

The block presents per-pin output data and tri-state enable signals to the pad cells. Register writes take one cycle and reads are combinational.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted and after it is released, the direction register reads 5'b11111, the latch reads 0, the port register reads 0, and no unselected pin is driven (pad_oe_o bit is 0).
- R2: A write to address 0 stores wdata_i into the direction register. Reading address 0 returns it from the next cycle on. An unselected pin has pad_oe_o = ~direction bit.
- R3: A write to address 1 (latch) and a write to address 2 (port) both store wdata_i into the same output latch, which is visible from the next cycle.
- R4: Reading address 1 returns the latch value, independent of the pin levels. On an unselected pin, pad_out_o equals the latch bit.
- R5: Reading address 2 returns the pin levels delayed by exactly two clock edges. Writes to address 2 do not change the value read there.
- R6: periph_di_o equals the same two-edge synchronized pin levels that address 2 returns.
- R7: When periph_sel_i bit is 1, pad_out_o for that pin equals periph_do_i for that pin in the same cycle.
- R8: When periph_sel_i bit is 1, pad_oe_o for that pin equals periph_oe_i. When it is 0, periph_oe_i has no effect and the direction bit decides.
- R9: periph_sel_i, periph_oe_i and periph_do_i never change the value read from the direction register or the latch.
- R10: Address 3 is unused. It reads as 0, and writes to it change neither the direction register nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 2 | Register address: 0 direction, 1 latch, 2 port, 3 unused |
| wdata_i | input | 5 | Write data |
| rdata_o | output | 5 | Combinational read data for addr_i |
| pin_i | input | 5 | Levels sensed at the pads |
| pad_out_o | output | 5 | Output data toward the pads |
| pad_oe_o | output | 5 | Pad driver enable, 1 = drive |
| periph_sel_i | input | 5 | Per-pin peripheral takeover |
| periph_do_i | input | 5 | Peripheral output data |
| periph_oe_i | input | 5 | Peripheral output enable, effective only when selected |
| periph_di_o | output | 5 | Synchronized pin levels for the peripherals |

## Verification
Two functions can coincide in one cycle. A software write to the direction register can land in the same cycle that a peripheral takes over or releases a pin. A latch write can also coincide with a pin level change on the port read path. The bench provokes both with a directed sequence, and then with a long random run in which writes, selects, enables and pin levels all change every cycle. A behavioural reference model, built from register variables and a queue of sampled pin levels, is compared with every output on every clock. This confirms that a selected pin follows the peripheral, that the direction readback still shows the value software wrote, and that unselected pins follow the new direction on the next cycle.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef enum logic [1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_LAT  = 2'd1,
    ADDR_PORT = 2'd2,
    ADDR_RSV  = 2'd3
  } gpio_addr_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_sync_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] rdata_o
);
  gpio_addr_e   addr;
  logic [W-1:0] dir_q, lat_q;
  logic         dir_we, lat_we;

  assign addr   = gpio_addr_e'(addr_i);
  assign dir_we = wr_en_i && (addr == ADDR_DIR);
  // port and latch addresses share one output latch
  assign lat_we = wr_en_i && ((addr == ADDR_LAT) || (addr == ADDR_PORT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      lat_q <= '0;
    end else begin
      if (dir_we) dir_q <= wdata_i;
      if (lat_we) lat_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_DIR:  rdata_o = dir_q;
      ADDR_LAT:  rdata_o = lat_q;
      ADDR_PORT: rdata_o = pin_sync_i;
      default:   rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/gpio_ovr_pad_mux.sv
module gpio_ovr_pad_mux #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] lat_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] pdo_i,
  input  logic [W-1:0] poe_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    // peripheral enable only counts while the pin is selected
    assign pad_out_o[g] = sel_i[g] ? pdo_i[g] : lat_i[g];
    assign pad_oe_o[g]  = sel_i[g] ? poe_i[g] : ~dir_i[g];
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  input  logic [W-1:0] periph_sel_i,
  input  logic [W-1:0] periph_do_i,
  input  logic [W-1:0] periph_oe_i,
  output logic [W-1:0] periph_di_o
);
  logic [W-1:0] pin_sync, dir, lat;

  gpio_ovr_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_ovr_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync),
    .dir_o     (dir),
    .lat_o     (lat),
    .rdata_o   (rdata_o)
  );

  gpio_ovr_pad_mux #(.W(W)) u_mux (
    .dir_i    (dir),
    .lat_i    (lat),
    .sel_i    (periph_sel_i),
    .pdo_i    (periph_do_i),
    .poe_i    (periph_oe_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o)
  );

  assign periph_di_o = pin_sync;
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W = 5
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] pin_i,
  input logic [W-1:0] pad_out_o,
  input logic [W-1:0] pad_oe_o,
  input logic [W-1:0] periph_sel_i,
  input logic [W-1:0] periph_do_i,
  input logic [W-1:0] periph_oe_i,
  input logic [W-1:0] periph_di_o
);
  logic [1:0] post_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) post_cnt <= '0;
    else if (post_cnt != 2'd2) post_cnt <= post_cnt + 2'd1;
  end

  // R2
  a_r2_dir_to_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_DIR) |=>
      ((pad_oe_o & ~periph_sel_i) == (~$past(wdata_i) & ~periph_sel_i)));

  // R3
  a_r3_latch_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == ADDR_LAT || addr_i == ADDR_PORT)) |=>
      (addr_i != ADDR_LAT || rdata_o == $past(wdata_i)));

  // R6
  a_r6_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_cnt == 2'd2) |-> (periph_di_o == $past(pin_i, 2)));

  // R7
  a_r7_sel_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ periph_do_i) & periph_sel_i) == '0);

  // R8
  a_r8_sel_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ periph_oe_i) & periph_sel_i) == '0);

  // R9
  a_r9_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_DIR && !wr_en_i) |=>
      (addr_i != ADDR_DIR || rdata_o == $past(rdata_o)));

  // R10
  a_r10_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_RSV) |-> (rdata_o == '0));
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.W(W)) u_chk (.*);

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0, pin = '0, sel = '0, pdo = '0, poe = '0;
  logic [W-1:0] rdata, pad_out, pad_oe, pdi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_ovr_port #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .periph_sel_i(sel), .periph_do_i(pdo),
    .periph_oe_i(poe), .periph_di_o(pdi)
  );

  // reference model
  logic [W-1:0] m_dir, m_lat;
  logic [W-1:0] m_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '1;
      m_lat = '0;
      m_hist.delete();
    end else begin
      if (wr_en && addr == 2'd0) m_dir = wdata;
      if (wr_en && (addr == 2'd1 || addr == 2'd2)) m_lat = wdata;
      m_hist.push_back(pin);
      if (m_hist.size() > 2) void'(m_hist.pop_front());
    end
  end

  function automatic logic [W-1:0] m_sync();
    return (m_hist.size() >= 2) ? m_hist[0] : '0;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] e_rd, e_out, e_oe;
    case (addr)
      2'd0: e_rd = m_dir;
      2'd1: e_rd = m_lat;
      2'd2: e_rd = m_sync();
      default: e_rd = '0;
    endcase
    e_out = (sel & pdo) | (~sel & m_lat);
    e_oe  = (sel & poe) | (~sel & ~m_dir);
    case (addr)
      2'd0: chk("R2/R9 dir readback", rdata, e_rd);
      2'd1: chk("R4/R3 latch readback", rdata, e_rd);
      2'd2: chk("R5 port readback", rdata, e_rd);
      default: chk("R10 unused address", rdata, e_rd);
    endcase
    chk("R7/R4 pad_out", pad_out, e_out);
    chk("R8/R2 pad_oe", pad_oe, e_oe);
    chk("R6 periph_di", pdi, m_sync());
  endtask

  task automatic cyc(input logic w, input logic [1:0] a, input logic [W-1:0] d,
                     input logic [W-1:0] p, input logic [W-1:0] s,
                     input logic [W-1:0] o, input logic [W-1:0] e);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; pin = p; sel = s; pdo = o; poe = e;
    #2;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with pins and peripheral enables active
    pin = 5'b10101; poe = '1;
    repeat (3) @(negedge clk);
    addr = 2'd0; #1 chk("R1 dir in reset", rdata, 5'b11111);
    chk("R1 oe in reset", pad_oe, 5'b00000);
    addr = 2'd1; #1 chk("R1 latch in reset", rdata, 5'b00000);
    addr = 2'd2; #1 chk("R1 port in reset", rdata, 5'b00000);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 2'd0, '0, 5'b10101, '0, '0, '1);
    cyc(0, 2'd1, '0, 5'b10101, '0, '0, '1);
    // R2: set pins 1:0 outputs
    cyc(1, 2'd0, 5'b11100, 5'b10101, '0, '0, '1);
    cyc(0, 2'd0, '0, 5'b10101, '0, '0, '0);
    // R3: latch via latch address, then via port address
    cyc(1, 2'd1, 5'b01010, 5'b00011, '0, '0, '0);
    cyc(0, 2'd1, '0, 5'b00011, '0, '0, '0);
    cyc(1, 2'd2, 5'b10011, 5'b00011, '0, '0, '0);
    cyc(0, 2'd1, '0, 5'b11111, '0, '0, '0);
    // R5: port tracks pins two edges later, not the latch
    cyc(0, 2'd2, '0, 5'b01100, '0, '0, '0);
    cyc(0, 2'd2, '0, 5'b01100, '0, '0, '0);
    cyc(0, 2'd2, '0, 5'b01100, '0, '0, '0);
    // R10: unused address write ignored
    cyc(1, 2'd3, 5'b00000, 5'b01100, '0, '0, '0);
    cyc(0, 2'd0, '0, 5'b01100, '0, '0, '0);
    cyc(0, 2'd1, '0, 5'b01100, '0, '0, '0);
    // R8/R9: dir write in the same cycle as a takeover of pins 4 and 0
    cyc(1, 2'd0, 5'b00110, 5'b01100, 5'b10001, 5'b10000, 5'b00001);
    cyc(0, 2'd0, '0, 5'b01100, 5'b10001, 5'b00001, 5'b10000);
    cyc(0, 2'd0, '0, 5'b01100, 5'b00000, 5'b11111, 5'b11111);
    cyc(0, 2'd1, '0, 5'b01100, 5'b11111, 5'b11111, 5'b11111);
    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      cyc(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), W'($urandom),
          W'($urandom), W'($urandom), W'($urandom), W'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule